// File: doc/BRIEF.md
# Half-Group Memory Access Coalescer

This block sits between the address-generation stage of a vector load/store unit and the memory request port. It accepts one memory instruction for a group of 16 lanes. Each lane gives an active flag and a byte address. The group shares one access-size code. The block turns the group into a short series of segment transactions. Each transaction carries an aligned base address, a byte count and a mask of the lanes it serves. A valid/ready pair drives the memory side. A one-cycle `done` pulse marks the end of the group.

In relaxed mode, each round starts from the lowest-numbered lane that is still pending. That lane's address picks a segment, and every other pending lane whose address falls inside the same segment joins the round. Before issue, the transaction shrinks to half its size, and then to half again, whenever the smaller window still covers every merged access. In strict mode, the whole group is served as one transaction only when every active lane k addresses word k of a segment-aligned block. Otherwise each active lane is served on its own, lowest lane first.

The controller is a four-state machine. ACCEPT_IDLE waits for `start`. It goes to PICK when at least one lane is active (transition *start_work*) and straight to WRAP when no lane is active (transition *start_empty*). PICK forms one round and always moves to OFFER (*formed*). OFFER holds the transaction until `tx_ready`. After the handshake it returns to PICK while lanes remain (*more_lanes*) and moves to WRAP when none remain (*last_served*). WRAP raises `done` for one cycle and returns to ACCEPT_IDLE (*retire*).

Top module: `halfgroup_coalescer`

## Requirements
- R1: After reset, `busy`, `done` and `tx_valid` are all low.
- R2: The segment size comes from `acc_log2`: code 0 (1-byte access) gives 32 bytes, code 1 (2-byte access) gives 64 bytes, and codes 2 and 3 (4- and 8-byte accesses) give 128 bytes.
- R3: Each round is led by the lowest-numbered pending lane, so the lead lane rises from one transaction to the next. The transaction base lies in the segment that holds the lead lane's address.
- R4: In relaxed mode, a transaction's mask holds exactly the pending lanes whose addresses share the lead lane's segment.
- R5: A 128-byte transaction whose merged accesses all lie in one 64-byte half is issued as 64 bytes. A 64-byte transaction whose merged accesses all lie in one 32-byte half is issued as 32 bytes. The base moves to the chosen half.
- R6: Lanes served by a transaction never appear in a later transaction of the same group. `done` rises for exactly one cycle, in the cycle after the last handshake.
- R7: Lanes with a low active flag are never placed in a mask. A group with no active lanes gives `done` one cycle after `start`, with no transaction.
- R8: In strict mode, the group is served by relaxed merging only if every active lane k has the address B + k·2^acc_log2, where B is a multiple of the segment size. Otherwise each active lane gets its own single-lane transaction, in ascending lane order.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_base`, `tx_bytes` and `tx_mask` stay unchanged and `tx_valid` stays high.
- R10: Every issued `tx_base` is a multiple of `tx_bytes`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Accept a new group (taken in ACCEPT_IDLE) |
| strict_mode | input | 1 | 1 = strict in-order grouping, 0 = relaxed |
| acc_log2 | input | 2 | log2 of access size in bytes |
| lane_act | input | 16 | Per-lane active flags |
| lane_addr | input | 512 | Lane byte addresses, lane i at bits [32i+31:32i] |
| busy | output | 1 | A group is in progress |
| done | output | 1 | One-cycle pulse when the group is complete |
| tx_valid | output | 1 | A transaction is offered |
| tx_ready | input | 1 | Memory side accepts the transaction |
| tx_base | output | 32 | Aligned transaction base address |
| tx_bytes | output | 8 | Transaction size: 32, 64 or 128 |
| tx_mask | output | 16 | Lanes served by the transaction |

## Verification
The bench builds the block with its defaults: 16 lanes and 32-bit addresses. It sweeps all four access-size codes, both modes, six address patterns (linear, same word, stride 2, reversed, stride 8, pairwise swap), three base offsets (aligned, small offset and 32-byte offset) and three active masks including the empty one. This covers every segment size, all three size-reduction outcomes, strict success and strict fallback, and broadcast addresses. Alternate runs stall `tx_ready` to exercise holding the transaction under back-pressure.

// File: rtl/coal_pkg.sv
package coal_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PICK,
        ST_OFFER,
        ST_WRAP
    } coal_state_e;

    // log2 of the segment size chosen by the access-size code
    function automatic logic [2:0] seg_log2(input logic [1:0] acc);
        if (acc >= 2'd2)      return 3'd7;
        else if (acc == 2'd1) return 3'd6;
        else                  return 3'd5;
    endfunction

endpackage

// File: rtl/coal_lead_pick.sv
module coal_lead_pick #(
    parameter int N = 16,
    localparam int LW = $clog2(N)
) (
    input  logic [N-1:0]  pending,
    output logic [LW-1:0] lead_idx,
    output logic          any
);
    always_comb begin
        lead_idx = '0;
        any      = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pending[i]) begin
                lead_idx = LW'(i);
                any      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/coal_strict_chk.sv
module coal_strict_chk #(
    parameter int N  = 16,
    parameter int AW = 32
) (
    input  logic [N*AW-1:0] addr,
    input  logic [N-1:0]    act,
    input  logic [1:0]      acc,
    input  logic [2:0]      seg_lg,
    output logic            ok
);
    logic [AW-1:0] low_mask;
    logic [AW-1:0] implied;
    logic [AW-1:0] first_b;
    logic          seen;

    assign low_mask = ~({AW{1'b1}} << seg_lg);

    always_comb begin
        ok      = 1'b1;
        seen    = 1'b0;
        first_b = '0;
        implied = '0;
        for (int i = 0; i < N; i++) begin
            implied = addr[i*AW +: AW] - (AW'(i) << acc);
            if (act[i]) begin
                if (!seen) begin
                    first_b = implied;
                    seen    = 1'b1;
                    if ((implied & low_mask) != '0) ok = 1'b0;
                end else if (implied != first_b) begin
                    ok = 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/coal_merge.sv
module coal_merge #(
    parameter int N  = 16,
    parameter int AW = 32,
    localparam int LW = $clog2(N)
) (
    input  logic [N*AW-1:0] addr,
    input  logic [N-1:0]    pending,
    input  logic [LW-1:0]   lead_idx,
    input  logic [2:0]      seg_lg,
    input  logic            solo,
    output logic [N-1:0]    mask,
    output logic [AW-1:0]   base,
    output logic [2:0]      size_lg
);
    logic [AW-1:0] seg_mask;
    logic [AW-1:0] lead_addr;
    logic [AW-1:0] seg_base;
    logic [N-1:0]  in_seg;
    logic [N-1:0]  bit6;
    logic [N-1:0]  bit5;

    assign seg_mask  = {AW{1'b1}} << seg_lg;
    assign lead_addr = addr[int'(lead_idx)*AW +: AW];
    assign seg_base  = lead_addr & seg_mask;

    for (genvar g = 0; g < N; g++) begin : g_lane
        assign in_seg[g] = pending[g] && ((addr[g*AW +: AW] & seg_mask) == seg_base);
        assign bit6[g]   = addr[g*AW + 6];
        assign bit5[g]   = addr[g*AW + 5];
    end

    assign mask = solo ? (N'(1) << lead_idx) : in_seg;

    always_comb begin
        size_lg = seg_lg;
        base    = seg_base;
        if (size_lg == 3'd7 && !((|(mask & bit6)) && (|(mask & ~bit6)))) begin
            size_lg = 3'd6;
            base[6] = |(mask & bit6);
        end
        if (size_lg == 3'd6 && !((|(mask & bit5)) && (|(mask & ~bit5)))) begin
            size_lg = 3'd5;
            base[5] = |(mask & bit5);
        end
    end
endmodule

// File: rtl/halfgroup_coalescer.sv
module halfgroup_coalescer
    import coal_pkg::*;
#(
    parameter int N  = 16,
    parameter int AW = 32,
    localparam int LW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            strict_mode,
    input  logic [1:0]      acc_log2,
    input  logic [N-1:0]    lane_act,
    input  logic [N*AW-1:0] lane_addr,
    output logic            busy,
    output logic            done,
    output logic            tx_valid,
    input  logic            tx_ready,
    output logic [AW-1:0]   tx_base,
    output logic [7:0]      tx_bytes,
    output logic [N-1:0]    tx_mask
);
    coal_state_e   state, state_nx;
    logic [N*AW-1:0] addr_q;
    logic [N-1:0]  act_q, pending_q, mask_q;
    logic [2:0]    seg_lg_q, lg_q;
    logic [AW-1:0] base_q;
    logic          solo_q;

    logic          strict_ok;
    logic [LW-1:0] lead_idx;
    logic          lead_any;
    logic [N-1:0]  m_mask;
    logic [AW-1:0] m_base;
    logic [2:0]    m_lg;

    coal_strict_chk #(.N(N), .AW(AW)) u_strict (
        .addr(lane_addr), .act(lane_act), .acc(acc_log2),
        .seg_lg(seg_log2(acc_log2)), .ok(strict_ok)
    );

    coal_lead_pick #(.N(N)) u_lead (
        .pending(pending_q), .lead_idx(lead_idx), .any(lead_any)
    );

    coal_merge #(.N(N), .AW(AW)) u_merge (
        .addr(addr_q), .pending(pending_q), .lead_idx(lead_idx),
        .seg_lg(seg_lg_q), .solo(solo_q),
        .mask(m_mask), .base(m_base), .size_lg(m_lg)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = (lane_act == '0) ? ST_WRAP : ST_PICK;
            ST_PICK:  state_nx = ST_OFFER;
            ST_OFFER: if (tx_ready)
                          state_nx = ((pending_q & ~mask_q) == '0) ? ST_WRAP : ST_PICK;
            ST_WRAP:  state_nx = ST_IDLE;
        endcase
    end

    // group and transaction registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            act_q     <= '0;
            pending_q <= '0;
            seg_lg_q  <= 3'd5;
            solo_q    <= 1'b0;
            base_q    <= '0;
            mask_q    <= '0;
            lg_q      <= 3'd5;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    addr_q    <= lane_addr;
                    act_q     <= lane_act;
                    pending_q <= lane_act;
                    seg_lg_q  <= seg_log2(acc_log2);
                    solo_q    <= strict_mode && !strict_ok;
                end
                ST_PICK: begin
                    base_q <= m_base;
                    mask_q <= m_mask;
                    lg_q   <= m_lg;
                end
                ST_OFFER: if (tx_ready) pending_q <= pending_q & ~mask_q;
                ST_WRAP: ;
            endcase
        end
    end

    assign busy     = (state != ST_IDLE);
    assign done     = (state == ST_WRAP);
    assign tx_valid = (state == ST_OFFER);
    assign tx_base  = base_q;
    assign tx_mask  = mask_q;
    assign tx_bytes = 8'd1 << lg_q;

    // R9
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_base) && $stable(tx_mask) && $stable(tx_bytes)));

    // R10
    base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> ((tx_base & (AW'(tx_bytes) - AW'(1))) == '0));

    // R7
    inactive_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> ((tx_mask & ~act_q) == '0 && tx_mask != '0));

    // R8
    solo_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && solo_q) |-> ($countones(tx_mask) == 1));

    // R6
    done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    served_gone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> ((tx_mask & ~pending_q) == '0));

    // R3
    lead_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PICK) |-> lead_any);

endmodule

// File: tb/halfgroup_coalescer_tb_top.sv
module halfgroup_coalescer_tb_top;
    localparam int N  = 16;
    localparam int AW = 32;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, strict_mode = 1'b0, tx_ready = 1'b0;
    logic [1:0]      acc_log2 = '0;
    logic [N-1:0]    lane_act = '0;
    logic [N*AW-1:0] lane_addr = '0;
    wire             busy, done, tx_valid;
    wire  [AW-1:0]   tx_base;
    wire  [7:0]      tx_bytes;
    wire  [N-1:0]    tx_mask;

    halfgroup_coalescer #(.N(N), .AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .strict_mode(strict_mode),
        .acc_log2(acc_log2), .lane_act(lane_act), .lane_addr(lane_addr),
        .busy(busy), .done(done), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_base(tx_base), .tx_bytes(tx_bytes), .tx_mask(tx_mask)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    longint a [N];
    int     exp_n;
    longint e_base [N];
    longint e_bytes [N];
    logic [N-1:0] e_mask [N];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic longint pat_idx(input int p, input int i);
        case (p)
            0: return longint'(i);
            1: return 0;
            2: return longint'(2 * i);
            3: return longint'(15 - i);
            4: return longint'(8 * i);
            default: return longint'(i ^ 1);
        endcase
    endfunction

    task automatic build_exp(input int acc, input bit strict, input logic [N-1:0] act);
        logic [N-1:0] pend;
        longint seg, sz, implied, sb, b, mn, mx, lo_off, hi_off;
        int lg, lead;
        bit solo;
        seg  = (acc >= 2) ? 128 : (acc == 1 ? 64 : 32);
        sz   = longint'(1) << acc;
        solo = 1'b0;
        exp_n = 0;
        if (strict && act != '0) begin
            lead = -1;
            for (int i = N - 1; i >= 0; i--) if (act[i]) lead = i;
            implied = a[lead] - lead * sz;
            if (implied % seg != 0) solo = 1'b1;
            for (int i = 0; i < N; i++)
                if (act[i] && a[i] != implied + i * sz) solo = 1'b1;
        end
        pend = act;
        while (pend != '0) begin
            lead = -1;
            for (int i = N - 1; i >= 0; i--) if (pend[i]) lead = i;
            sb = (a[lead] / seg) * seg;
            e_mask[exp_n] = '0;
            if (solo) e_mask[exp_n][lead] = 1'b1;
            else for (int i = 0; i < N; i++)
                if (pend[i] && (a[i] / seg) == (a[lead] / seg)) e_mask[exp_n][i] = 1'b1;
            mn = seg; mx = 0;
            for (int i = 0; i < N; i++) if (e_mask[exp_n][i]) begin
                if (a[i] - sb < mn) mn = a[i] - sb;
                if (a[i] - sb + sz - 1 > mx) mx = a[i] - sb + sz - 1;
            end
            b  = sb;
            lg = (acc >= 2) ? 7 : 5 + acc;
            while (lg > 5) begin
                lo_off = (mn - (b - sb)) >> (lg - 1);
                hi_off = (mx - (b - sb)) >> (lg - 1);
                if (lo_off != hi_off) break;
                b  = b + (lo_off << (lg - 1));
                lg = lg - 1;
            end
            e_base[exp_n]  = b;
            e_bytes[exp_n] = longint'(1) << lg;
            pend = pend & ~e_mask[exp_n];
            exp_n++;
        end
    endtask

    task automatic run_group(input int acc, input bit strict, input logic [N-1:0] act,
                             input bit stall);
        int got, since, cyc;
        bit fin, hold;
        longint h_base, h_bytes;
        logic [N-1:0] h_mask, seen;
        build_exp(acc, strict, act);
        @(negedge clk);
        acc_log2    = 2'(acc);
        strict_mode = strict;
        lane_act    = act;
        for (int i = 0; i < N; i++) lane_addr[i*AW +: AW] = AW'(a[i]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        got = 0; since = 1; fin = 1'b0; hold = 1'b0; seen = '0;
        h_base = 0; h_bytes = 0; h_mask = '0;
        for (cyc = 0; cyc < 600 && !fin; cyc++) begin
            if (hold) begin
                check(tx_valid && longint'(tx_base) == h_base && longint'(tx_bytes) == h_bytes
                      && tx_mask == h_mask, "R9", "held transaction",
                      longint'(tx_base), h_base);
                hold = 1'b0;
            end
            if (done) begin
                check(since == 1, "R6", "done delay after last event", since, 1);
                fin = 1'b1;
            end else begin
                tx_ready = stall ? (cyc % 3 == 2) : 1'b1;
                if (tx_valid && !tx_ready) begin
                    hold = 1'b1;
                    h_base = longint'(tx_base); h_bytes = longint'(tx_bytes); h_mask = tx_mask;
                end
                if (tx_valid && tx_ready) begin
                    if (got < exp_n) begin
                        check(longint'(tx_base) == e_base[got], "R3", "base",
                              longint'(tx_base), e_base[got]);
                        check(longint'(tx_bytes) == e_bytes[got], "R2 R5", "bytes",
                              longint'(tx_bytes), e_bytes[got]);
                        check(tx_mask == e_mask[got], "R4 R8", "mask",
                              longint'(tx_mask), longint'(e_mask[got]));
                    end
                    check((tx_mask & ~act) == '0, "R7", "inactive lane served",
                          longint'(tx_mask), longint'(act));
                    check((tx_mask & seen) == '0, "R6", "lane served twice",
                          longint'(tx_mask & seen), 0);
                    check(longint'(tx_base) % longint'(tx_bytes) == 0, "R10", "alignment",
                          longint'(tx_base), longint'(tx_bytes));
                    seen = seen | tx_mask;
                    got++;
                    since = 0;
                end
                since++;
                @(negedge clk);
            end
        end
        tx_ready = 1'b0;
        check(fin, "R6", "done seen", fin, 1);
        check(got == exp_n, (act == '0) ? "R7" : "R6", "transaction count", got, exp_n);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [N-1:0] masks [3];
        longint offs [3];
        masks[0] = 16'hFFFF; masks[1] = 16'h5AF0; masks[2] = 16'h0000;
        offs[0] = 0; offs[1] = 8; offs[2] = 4128;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !done && !tx_valid, "R1", "reset outputs",
              longint'({busy, done, tx_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !tx_valid, "R1", "idle after reset",
              longint'({busy, done, tx_valid}), 0);
        for (int acc = 0; acc < 4; acc++)
            for (int p = 0; p < 6; p++)
                for (int o = 0; o < 3; o++)
                    for (int m = 0; m < 3; m++)
                        for (int s = 0; s < 2; s++) begin
                            for (int i = 0; i < N; i++)
                                a[i] = 4096 + offs[o] + pat_idx(p, i) * (longint'(1) << acc);
                            run_group(acc, s[0], masks[m], (p + o) % 2 == 1);
                        end
        // R8: strict fallback with a single misplaced lane
        for (int i = 0; i < N; i++) a[i] = 8192 + i * 4;
        a[9] = 8192 + 4;
        run_group(2, 1'b1, 16'hFFFF, 1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule